// File: doc/BRIEF.md
# Cascadable Display Column Data Loader

This block is the digital front end of a column driver for an active-matrix panel. Every clock it takes three 6-bit dot codes from a shared input bus and writes them into one group of three columns of a data register. Which group gets written is chosen by a fill pointer. The pointer starts when a start token arrives on the entry-side start input. It then walks across the groups, one group per clock. When it has written the last group, it sends a one-clock start token out of the far side, so the next chip in a daisy chain can take over the bus.

A rising edge on the strobe input copies the whole data register into an output latch. The latch presents one 6-bit code per column to the converters downstream. The same edge sends the pointer back to idle, so every line needs a fresh start token.

The fill can run in either direction. Data can be stored bit-inverted. A narrow mode jumps over a central band of columns, which shortens a line by six clocks.

Top module: `col_data_loader`

## Requirements
- R1: In full mode (`wide_sel`=1) a line writes all 134 groups. Group g (0-based) holds columns 3g, 3g+1 and 3g+2. Lane l of `dot_in` (bits 6l+5 down to 6l, with bit 6l the LSB) goes to column 3g+l. Column c appears on `codes_out[6c+5:6c]`.
- R2: In narrow mode (`wide_sel`=0) a line writes 128 groups. Groups 64 to 69 (columns 192 to 209) are jumped over, and their stored codes keep whatever they held before.
- R3: With `dir_right`=1 the token enters on `start_r_in`, the fill runs from group 0 upward, and the outgoing token leaves on `start_l_out` while `start_r_out` stays low. With `dir_right`=0 the token enters on `start_l_in`, the fill runs from group 133 downward, and it leaves on `start_r_out` while `start_l_out` stays low.
- R4: When the start input is sampled high at edge k while the pointer is idle, edge k+1 writes the first group of the fill order. Each later edge writes the next group.
- R5: The outgoing start token is high for exactly one clock, the cycle that follows the edge writing the last group. That edge is k+134 in full mode and k+128 in narrow mode. The token is low at all other times.
- R6: When `invert` is 1 at a write edge, each stored 6-bit code is the bitwise complement of its lane. When `invert` is 0, the lane is stored unchanged.
- R7: A rising edge of `strobe` (sampled at a clock edge) copies the data register into the output latch and returns the pointer to idle. No further group is written until a new start token arrives.
- R8: Clock edges after the last group of a line and before the strobe leave the data register unchanged, whatever `dot_in` carries.
- R9: `codes_out` changes only on a strobe rising edge. Between strobes it holds its value, including while a new line is being written.
- R10: After a synchronous active-low reset, `codes_out` is all zeros, both start outputs are low and the pointer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_right | input | 1 | Fill direction: 1 = ascending groups, 0 = descending |
| wide_sel | input | 1 | 1 = all 402 columns, 0 = 384 columns with the centre band skipped (tie high by default) |
| invert | input | 1 | Store the complement of each dot code |
| start_r_in | input | 1 | Start token input used when `dir_right`=1 |
| start_l_in | input | 1 | Start token input used when `dir_right`=0 |
| start_r_out | output | 1 | Outgoing token when `dir_right`=0, low otherwise |
| start_l_out | output | 1 | Outgoing token when `dir_right`=1, low otherwise |
| dot_in | input | 18 | Three 6-bit dot lanes, lane 0 in bits 5:0 |
| strobe | input | 1 | Line latch strobe, acts on its rising edge |
| codes_out | output | 2412 | Latched 6-bit code for each of the 402 columns |

## Verification
The bench goes after the places where the pointer is most likely to go wrong. It checks that both narrow-mode jumps land on the correct neighbour in each direction. A wrong jump would overwrite the dead band or drop one or two groups next to it.

It counts the exact clock on which the outgoing token fires. A pointer that is off by one would make the next chip in the chain lose or repeat a group.

It also checks that a strobe in the middle of a line really stops the pointer, and that surplus clocks after a line do not write anything. A design that ignores either would leave stale or garbage codes in the latched line. Inversion, and the claim that the latch stays put while the next line fills, are checked at the output port.

// File: rtl/col_loader_pkg.sv
// Package: col_loader_pkg
// Holds the default geometry of the column loader and the pointer state type.
// Assumes one loader per package user; no run-time state lives here.
package col_loader_pkg;

    localparam int DEF_GROUPS   = 134;  // groups of columns in full mode
    localparam int DEF_LANES    = 3;    // dots written per clock
    localparam int DEF_DOT_W    = 6;    // bits per dot code
    localparam int DEF_SKIP_LO  = 64;   // first group of the narrow-mode gap
    localparam int DEF_SKIP_CNT = 6;    // groups in the narrow-mode gap

    typedef enum logic {
        PTR_IDLE = 1'b0,
        PTR_FILL = 1'b1
    } ptr_state_e;

endpackage

// File: rtl/col_ptr_seq.sv
// Module: col_ptr_seq
// Fill pointer for the column loader. It starts on a start token and steps one
// group per clock in the captured direction. In narrow mode it jumps over the
// gap groups. After the last group it raises a one-clock outgoing token.
// A strobe rising edge forces it idle.
// Assumes: the direction and the mode are captured at the start and held for
// the whole line; the strobe never lands on the edge that writes the last group.
module col_ptr_seq
    import col_loader_pkg::*;
#(
    parameter int GROUPS   = DEF_GROUPS,
    parameter int SKIP_LO  = DEF_SKIP_LO,
    parameter int SKIP_CNT = DEF_SKIP_CNT,
    localparam int GRP_W   = $clog2(GROUPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_seen,
    input  logic             dir_right,
    input  logic             wide_sel,
    input  logic             strobe_rise,
    output logic             wr_en,
    output logic [GRP_W-1:0] wr_grp,
    output logic             cascade
);

    localparam int SKIP_HI = SKIP_LO + SKIP_CNT;   // first group after the gap

    ptr_state_e       state_q;
    logic [GRP_W-1:0] grp_q;
    logic             dir_q;
    logic             wide_q;
    logic             cascade_q;

    logic [GRP_W-1:0] first_grp;
    logic [GRP_W-1:0] last_grp;
    logic [GRP_W-1:0] next_grp;

    // Purpose: work out the entry group, the final group and the successor group.
    always_comb begin
        first_grp = dir_right ? '0 : GRP_W'(GROUPS - 1);
        last_grp  = dir_q ? GRP_W'(GROUPS - 1) : '0;
        if (dir_q) begin
            if (!wide_q && (grp_q == GRP_W'(SKIP_LO - 1)))
                next_grp = GRP_W'(SKIP_HI);
            else
                next_grp = grp_q + 1'b1;
        end else begin
            if (!wide_q && (grp_q == GRP_W'(SKIP_HI)))
                next_grp = GRP_W'(SKIP_LO - 1);
            else
                next_grp = grp_q - 1'b1;
        end
    end

    // Purpose: step the pointer, capture the line settings, emit the outgoing token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= PTR_IDLE;
            grp_q     <= '0;
            dir_q     <= 1'b1;
            wide_q    <= 1'b1;
            cascade_q <= 1'b0;
        end else begin
            cascade_q <= 1'b0;
            if (strobe_rise) begin
                state_q <= PTR_IDLE;
            end else if (state_q == PTR_IDLE) begin
                if (start_seen) begin
                    state_q <= PTR_FILL;
                    grp_q   <= first_grp;
                    dir_q   <= dir_right;
                    wide_q  <= wide_sel;
                end
            end else begin
                if (grp_q == last_grp) begin
                    state_q   <= PTR_IDLE;
                    cascade_q <= 1'b1;
                end else begin
                    grp_q <= next_grp;
                end
            end
        end
    end

    assign wr_en   = (state_q == PTR_FILL) && !strobe_rise;
    assign wr_grp  = grp_q;
    assign cascade = cascade_q;

    // R5: the outgoing token lasts a single clock
    assert_token_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_q |=> !cascade_q);

    // R5: the token can only follow a cycle in which the pointer was filling
    assert_token_after_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cascade_q) |-> $past(state_q == PTR_FILL));

    // R7: a strobe edge always leaves the pointer idle
    assert_strobe_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_rise |=> (state_q == PTR_IDLE));

    // R2: the narrow-mode pointer never sits inside the gap
    assert_gap_avoided_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PTR_FILL && !wide_q) |->
            !((int'(grp_q) >= SKIP_LO) && (int'(grp_q) < SKIP_HI)));

    // R1: the pointer stays within the group range
    assert_grp_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PTR_FILL) |-> (int'(grp_q) < GROUPS));

    // R10: reset leaves the pointer idle with no token
    assert_reset_idle_R10: assert property (@(posedge clk)
        !rst_n |=> (state_q == PTR_IDLE && !cascade_q));

endmodule

// File: rtl/col_data_reg.sv
// Module: col_data_reg
// Per-column data register. Each group of LANES columns is written from the
// input bus when the pointer selects it, with optional bitwise inversion.
// Assumes: at most one group is selected per clock; groups that are not
// selected keep their contents.
module col_data_reg
    import col_loader_pkg::*;
#(
    parameter int GROUPS  = DEF_GROUPS,
    parameter int LANES   = DEF_LANES,
    parameter int DOT_W   = DEF_DOT_W,
    localparam int GRP_W  = $clog2(GROUPS),
    localparam int IN_W   = LANES * DOT_W,
    localparam int REG_W  = GROUPS * IN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [GRP_W-1:0] wr_grp,
    input  logic             invert,
    input  logic [IN_W-1:0]  dot_in,
    output logic [REG_W-1:0] reg_flat
);

    logic [IN_W-1:0] store_word;

    // Purpose: apply the optional inversion to all lanes at once.
    always_comb begin
        store_word = dot_in ^ {IN_W{invert}};
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        logic [IN_W-1:0] grp_q;

        // Purpose: load this group when the pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                grp_q <= '0;
            else if (wr_en && (wr_grp == GRP_W'(g)))
                grp_q <= store_word;
        end

        assign reg_flat[g*IN_W +: IN_W] = grp_q;
    end

    // R8: with no write enabled the register does not move
    assert_reg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_flat));

endmodule

// File: rtl/col_out_latch.sv
// Module: col_out_latch
// Output latch that takes a copy of the data register on a strobe edge.
// Assumes: load is a single-cycle pulse derived from the strobe edge.
module col_out_latch #(
    parameter int WIDTH = 2412
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] q_r;

    // Purpose: capture the whole line on a load pulse, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_r <= '0;
        else if (load)
            q_r <= d;
    end

    assign q = q_r;

    // R9: the presented codes move only on a load pulse
    assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q_r));

endmodule

// File: rtl/col_data_loader.sv
// Module: col_data_loader (top)
// Front end of a cascadable display column driver. It routes the start token
// by direction, detects the strobe edge, and ties together the fill pointer,
// the data register and the output latch.
// Assumes: strobe high for two or more clocks; start low for two or more clocks
// between tokens; strobe rises no sooner than one clock after the last write.
module col_data_loader
    import col_loader_pkg::*;
#(
    parameter int NUM_GROUPS = DEF_GROUPS,
    parameter int LANES      = DEF_LANES,
    parameter int DOT_W      = DEF_DOT_W,
    parameter int SKIP_LO    = DEF_SKIP_LO,
    parameter int SKIP_CNT   = DEF_SKIP_CNT,
    localparam int NUM_COLS  = NUM_GROUPS * LANES,
    localparam int IN_W      = LANES * DOT_W,
    localparam int CODE_W    = NUM_COLS * DOT_W,
    localparam int GRP_W     = $clog2(NUM_GROUPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_right,
    input  logic              wide_sel,
    input  logic              invert,
    input  logic              start_r_in,
    input  logic              start_l_in,
    output logic              start_r_out,
    output logic              start_l_out,
    input  logic [IN_W-1:0]   dot_in,
    input  logic              strobe,
    output logic [CODE_W-1:0] codes_out
);

    logic             strobe_q;
    logic             strobe_rise;
    logic             start_seen;
    logic             wr_en;
    logic [GRP_W-1:0] wr_grp;
    logic             cascade;
    logic [CODE_W-1:0] reg_flat;

    // Purpose: remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe_q <= 1'b0;
        else
            strobe_q <= strobe;
    end

    // Purpose: pick the entry-side token and find the strobe rising edge.
    always_comb begin
        strobe_rise = strobe && !strobe_q;
        start_seen  = dir_right ? start_r_in : start_l_in;
    end

    // Purpose: send the outgoing token out of the far side only.
    always_comb begin
        start_l_out = cascade && dir_right;
        start_r_out = cascade && !dir_right;
    end

    col_ptr_seq #(
        .GROUPS   (NUM_GROUPS),
        .SKIP_LO  (SKIP_LO),
        .SKIP_CNT (SKIP_CNT)
    ) ptr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_seen  (start_seen),
        .dir_right   (dir_right),
        .wide_sel    (wide_sel),
        .strobe_rise (strobe_rise),
        .wr_en       (wr_en),
        .wr_grp      (wr_grp),
        .cascade     (cascade)
    );

    col_data_reg #(
        .GROUPS (NUM_GROUPS),
        .LANES  (LANES),
        .DOT_W  (DOT_W)
    ) dreg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_grp   (wr_grp),
        .invert   (invert),
        .dot_in   (dot_in),
        .reg_flat (reg_flat)
    );

    col_out_latch #(
        .WIDTH (CODE_W)
    ) olat_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (strobe_rise),
        .d     (reg_flat),
        .q     (codes_out)
    );

    // R3: the two outgoing start pins are never high together
    assert_one_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_l_out && start_r_out));

    // R10: after reset neither outgoing start pin is high
    assert_reset_exits_low_R10: assert property (@(posedge clk)
        !rst_n |=> (!start_l_out && !start_r_out));

endmodule

// File: tb/col_data_loader_tb_top.sv
// Directed bench for col_data_loader. Each scenario task drives a line and
// checks its own results against a model built from the requirements.
module col_data_loader_tb_top;

    localparam int NG   = 134;
    localparam int NL   = 3;
    localparam int DW   = 6;
    localparam int NC   = NG * NL;
    localparam int GLO  = 64;
    localparam int GCNT = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            dir_right = 1'b1;
    logic            wide_sel = 1'b1;
    logic            invert = 1'b0;
    logic            start_r_in = 1'b0;
    logic            start_l_in = 1'b0;
    logic            start_r_out;
    logic            start_l_out;
    logic [NL*DW-1:0] dot_in = '0;
    logic            strobe = 1'b0;
    logic [NC*DW-1:0] codes_out;

    int total = 0;
    int bad = 0;

    logic [DW-1:0] mdl_reg [NC];
    logic [DW-1:0] mdl_lat [NC];
    int            seq [NG];
    int            seq_len;

    always #4 clk = ~clk;

    col_data_loader dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .dir_right   (dir_right),
        .wide_sel    (wide_sel),
        .invert      (invert),
        .start_r_in  (start_r_in),
        .start_l_in  (start_l_in),
        .start_r_out (start_r_out),
        .start_l_out (start_l_out),
        .dot_in      (dot_in),
        .strobe      (strobe),
        .codes_out   (codes_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int seed, input int idx, input int lane);
        return DW'((seed * 13 + idx * 5 + lane * 23 + 1) % 64);
    endfunction

    // compare every column of codes_out with the latch model
    task automatic cmp_latch(input string req);
        int nbad = 0;
        int fc = 0;
        int fa = 0;
        int fe = 0;
        for (int c = 0; c < NC; c++) begin
            if (codes_out[c*DW +: DW] !== mdl_lat[c]) begin
                if (nbad == 0) begin
                    fc = c;
                    fa = int'(codes_out[c*DW +: DW]);
                    fe = int'(mdl_lat[c]);
                end
                nbad++;
            end
        end
        check(nbad == 0, req, $sformatf("codes_out column %0d (%0d columns off)", fc, nbad), fa, fe);
    endtask

    // fill order per R1/R2/R3
    task automatic build_seq(input bit dir, input bit wide);
        seq_len = 0;
        for (int i = 0; i < NG; i++) begin
            int g;
            g = dir ? i : NG - 1 - i;
            if (wide || g < GLO || g >= GLO + GCNT) begin
                seq[seq_len] = g;
                seq_len++;
            end
        end
    endtask

    task automatic pulse_strobe();
        strobe = 1'b1;
        @(negedge clk);
        @(negedge clk);
        strobe = 1'b0;
        @(negedge clk);
    endtask

    // drive one line; nw < 0 means complete line; extra clocks of junk after
    task automatic run_line(input bit dir, input bit wide, input bit inv,
                            input int seed, input int nw_req, input int extra,
                            input string req);
        int nw;
        build_seq(dir, wide);
        nw = (nw_req < 0) ? seq_len : nw_req;
        @(negedge clk);
        dir_right = dir;
        wide_sel  = wide;
        invert    = inv;
        if (dir) start_r_in = 1'b1; else start_l_in = 1'b1;
        @(negedge clk);                     // edge k sampled the token
        start_r_in = 1'b0;
        start_l_in = 1'b0;
        for (int i = 0; i < nw; i++) begin
            if (nw_req < 0 && i == nw - 1) begin
                check(!start_l_out && !start_r_out, "R5", "token early", int'(start_l_out | start_r_out), 0);
            end
            for (int l = 0; l < NL; l++) dot_in[l*DW +: DW] = pat(seed, i, l);
            invert = inv;
            @(negedge clk);                 // edge k+1+i writes seq[i]
            for (int l = 0; l < NL; l++)
                mdl_reg[seq[i]*NL + l] = pat(seed, i, l) ^ {DW{inv}};
        end
        if (nw_req < 0) begin
            // R5, R3: token out the far side right after the last write
            check((dir ? start_l_out : start_r_out) == 1'b1, "R5", "token after last group",
                  int'(dir ? start_l_out : start_r_out), 1);
            check((dir ? start_r_out : start_l_out) == 1'b0, "R3", "entry-side output",
                  int'(dir ? start_r_out : start_l_out), 0);
        end
        for (int e = 0; e < extra; e++) begin
            dot_in = NL*DW'($urandom);
            invert = ~inv;
            @(negedge clk);
            if (e == 0)
                check(!start_l_out && !start_r_out, "R5", "token width", int'(start_l_out | start_r_out), 0);
        end
        // R9: latch untouched while the line filled
        cmp_latch(req == "R9" ? "R9" : "R9 (during fill)");
        pulse_strobe();
        for (int c = 0; c < NC; c++) mdl_lat[c] = mdl_reg[c];
        cmp_latch(req);
    endtask

    task automatic t_reset();
        for (int c = 0; c < NC; c++) begin
            mdl_reg[c] = '0;
            mdl_lat[c] = '0;
        end
        cmp_latch("R10");
        check(!start_l_out && !start_r_out, "R10", "start outputs after reset",
              int'(start_l_out | start_r_out), 0);
    endtask

    task automatic t_full_right();
        run_line(1'b1, 1'b1, 1'b0, 3, -1, 2, "R1 R4");
    endtask

    task automatic t_full_left_inv();
        run_line(1'b0, 1'b1, 1'b1, 9, -1, 2, "R3 R6");
    endtask

    task automatic t_narrow_right();
        run_line(1'b1, 1'b0, 1'b0, 21, -1, 3, "R2");
    endtask

    task automatic t_narrow_left();
        run_line(1'b0, 1'b0, 1'b1, 30, -1, 1, "R2");
    endtask

    task automatic t_junk_after_line();
        run_line(1'b1, 1'b1, 1'b0, 44, -1, 20, "R8");
    endtask

    // strobe mid-line stops the pointer; later clocks write nothing
    task automatic t_strobe_abort();
        run_line(1'b1, 1'b1, 1'b1, 57, 10, 0, "R7");
        for (int e = 0; e < 30; e++) begin
            dot_in = NL*DW'($urandom);
            @(negedge clk);
        end
        check(!start_l_out && !start_r_out, "R7", "no token after abort",
              int'(start_l_out | start_r_out), 0);
        pulse_strobe();
        cmp_latch("R7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_right();
        t_full_left_inv();
        t_narrow_right();
        t_narrow_left();
        t_junk_after_line();
        t_strobe_abort();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule